// File: doc/BRIEF.md
# Per-Processor Prioritized Interrupt Controller

This block gathers interrupt requests for a four-processor cluster and, for each processor, reports the most urgent request that the processor has enabled. Six request levels exist, numbered 1 (lowest) to 6 (highest). Level 1 carries a software interrupt that any processor can post to any other. Level 5 carries that processor's timer tick. Levels 2, 3, 4 and 6 come straight from four shared external request lines. Each processor owns a small set of registers on a single-cycle register bus: an enable/status register, a software-interrupt register and a timer-acknowledge register.

The status register is asymmetric. A write loads a six-bit enable mask from the top six data bits. A read returns the reported level in the top three bits and the stored mask, moved down to bits 23..18. A software interrupt is posted by writing all ones and is withdrawn by reading the same register. A separate global register, when written, pulses a reset line towards every processor.

Top module: `percpu_irq_ctrl`

## Requirements
- R1: After reset every enable mask is zero, every reported level is 0, every `cpu_irq` bit is low, `cpu_reset_all` is low and no software or timer interrupt is pending.
- R2: Byte address 16*c + 0 is the status register of processor c. A write there loads wdata[31:26] as the enables for levels 6..1 (bit 31 is level 6, bit 26 is level 1, 1 enables). A read returns that mask in rdata[23:18], in the same bit order. Bits 28..24 and 17..0 read as zero.
- R3: A read of the status register returns the processor's reported level as a binary code in rdata[31:29].
- R4: The reported level is the highest level that is both pending and enabled, or 0 if there is none. Level 1 is the software interrupt, level 5 is the timer tick, and ext_irq[0], [1], [2], [3] drive levels 2, 3, 4, 6.
- R5: `cpu_irq[c]` is high exactly when the level of processor c is nonzero. Both are registered. A change on `ext_irq` first shows on the level one clock edge later, and a register write first shows two edges later.
- R6: A write of all ones to address 16*c + 4 posts a software interrupt to processor c. A write of any other value there has no effect.
- R7: A read of address 16*c + 4 returns zero and withdraws processor c's pending software interrupt.
- R8: A pulse on `timer_tick[c]` makes the timer interrupt of processor c pending. A write of all ones to address 16*c + 8 clears it. A write of any other value there has no effect.
- R9: A timer tick that coincides with an acknowledge write leaves the timer interrupt pending. A software-interrupt post that coincides with a read of the same register leaves the software interrupt pending.
- R10: Every processor's register set is independent. Posting, acknowledging or masking on one processor changes no other processor's level.
- R11: A write of any value to byte address 0x40 drives `cpu_reset_all` high for exactly the one cycle after the write edge. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| ext_irq | input | 4 | Shared external requests for levels 2, 3, 4, 6 |
| timer_tick | input | 4 | Per-processor timer tick pulses |
| cpu_level | output | 12 | Reported level per processor, 3 bits each, processor 0 lowest |
| cpu_irq | output | 4 | Interrupt request per processor |
| cpu_reset_all | output | 1 | Reset pulse to all processors |

## Verification
The bench sweeps each processor through all 64 pending patterns against all 64 enable masks. The expected code is worked out arithmetically, which separates a wrong priority order, a misplaced source level and a mask bit that is reversed or shifted. The readback of the same sweep shows whether the mask field and the level field are in their proper positions. Directed sequences then cover the timing: an external request seen one edge late, posts and acknowledges that coincide, writes that are not all ones, and cross-processor traffic, which exposes set/clear priority errors and decode aliasing between processor slots.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W     = 32;
    localparam int LVL_N      = 6;
    localparam int CODE_W     = $clog2(LVL_N + 1);
    localparam int EXT_N      = LVL_N - 2;
    localparam int SWI_LVL    = 1;
    localparam int TICK_LVL   = 5;
    localparam int MASK_WR_HI = DATA_W - 1;
    localparam int MASK_RD_LO = 18;
    localparam int CODE_LO    = DATA_W - CODE_W;
    localparam int SLOT_SHIFT = 4;

    localparam logic [1:0] REG_STAT = 2'd0;
    localparam logic [1:0] REG_SWI  = 2'd1;
    localparam logic [1:0] REG_ACK  = 2'd2;

    typedef struct packed {
        logic [LVL_N-1:0]  mask;
        logic              swi;
        logic              tick;
        logic [CODE_W-1:0] level;
        logic              irq;
    } slice_st_t;

    // Place software and timer sources at their levels; externals fill the rest upward.
    function automatic logic [LVL_N-1:0] gather_pending(
        input logic [EXT_N-1:0] ext,
        input logic             swi,
        input logic             tick
    );
        logic [LVL_N-1:0] vec;
        int j;
        vec = '0;
        j = 0;
        for (int i = 0; i < LVL_N; i++) begin
            if (i == SWI_LVL - 1) begin
                vec[i] = swi;
            end else if (i == TICK_LVL - 1) begin
                vec[i] = tick;
            end else begin
                vec[i] = ext[j];
                j++;
            end
        end
        return vec;
    endfunction
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int N = 6,
    parameter int W = $clog2(N + 1)
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] code
);
    // One-based index of the highest set bit, zero when empty.
    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) code = W'(i + 1);
        end
    end
endmodule

// File: rtl/irqc_cpu_slice.sv
module irqc_cpu_slice
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_we,
    input  logic              swi_we,
    input  logic              swi_re,
    input  logic              ack_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic [EXT_N-1:0]  ext_irq,
    output logic [LVL_N-1:0]  mask_o,
    output logic              swi_o,
    output logic              tick_o,
    output logic [CODE_W-1:0] level_o,
    output logic              irq_o
);
    slice_st_t st_d, st_q;
    logic [LVL_N-1:0]  pend_vec;
    logic [CODE_W-1:0] code_w;
    logic              ones_w;

    assign ones_w   = &wdata;
    assign pend_vec = gather_pending(ext_irq, st_q.swi, st_q.tick);

    irqc_prio_enc #(.N(LVL_N), .W(CODE_W)) u_enc (
        .req  (pend_vec & st_q.mask),
        .code (code_w)
    );

    always_comb begin
        st_d = st_q;
        if (stat_we) st_d.mask = wdata[MASK_WR_HI -: LVL_N];
        // clear first, then set, so a coincident set wins
        if (swi_re)            st_d.swi  = 1'b0;
        if (swi_we && ones_w)  st_d.swi  = 1'b1;
        if (ack_we && ones_w)  st_d.tick = 1'b0;
        if (tick)              st_d.tick = 1'b1;
        st_d.level = code_w;
        st_d.irq   = (code_w != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o  = st_q.mask;
    assign swi_o   = st_q.swi;
    assign tick_o  = st_q.tick;
    assign level_o = st_q.level;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/percpu_irq_ctrl.sv
module percpu_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] RESET_ALL_ADDR = 8'h40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [EXT_N-1:0]       ext_irq,
    input  logic [NCPU-1:0]        timer_tick,
    output logic [NCPU*CODE_W-1:0] cpu_level,
    output logic [NCPU-1:0]        cpu_irq,
    output logic                   cpu_reset_all
);
    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    logic [NCPU*LVL_N-1:0] mask_vec;
    logic [NCPU-1:0]       swi_vec;
    logic [NCPU-1:0]       tick_vec;
    logic [NCPU-1:0]       slot_hit;
    logic [1:0]            reg_sel;
    logic                  rst_all_d, rst_all_q;

    assign reg_sel = bus_addr[3:2];

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign slot_hit[c] = (bus_addr[ADDR_W-1:SLOT_SHIFT] == SLOT_W'(c)) &&
                             (bus_addr[1:0] == 2'b00);

        irqc_cpu_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .stat_we (bus_wr && slot_hit[c] && reg_sel == REG_STAT),
            .swi_we  (bus_wr && slot_hit[c] && reg_sel == REG_SWI),
            .swi_re  (bus_rd && slot_hit[c] && reg_sel == REG_SWI),
            .ack_we  (bus_wr && slot_hit[c] && reg_sel == REG_ACK),
            .wdata   (bus_wdata),
            .tick    (timer_tick[c]),
            .ext_irq (ext_irq),
            .mask_o  (mask_vec[c*LVL_N +: LVL_N]),
            .swi_o   (swi_vec[c]),
            .tick_o  (tick_vec[c]),
            .level_o (cpu_level[c*CODE_W +: CODE_W]),
            .irq_o   (cpu_irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (bus_rd && slot_hit[c] && reg_sel == REG_STAT) begin
                bus_rdata[CODE_LO +: CODE_W]   = cpu_level[c*CODE_W +: CODE_W];
                bus_rdata[MASK_RD_LO +: LVL_N] = mask_vec[c*LVL_N +: LVL_N];
            end
        end
    end

    always_comb begin
        rst_all_d = bus_wr && (bus_addr == RESET_ALL_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_all_q <= 1'b0;
        else        rst_all_q <= rst_all_d;
    end

    assign cpu_reset_all = rst_all_q;
endmodule

// File: rtl/irqc_sva.sv
module irqc_sva
    import irqc_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] RESET_ALL_ADDR = 8'h40
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [NCPU-1:0]        timer_tick,
    input logic [NCPU*CODE_W-1:0] cpu_level,
    input logic [NCPU-1:0]        cpu_irq,
    input logic                   cpu_reset_all,
    input logic [NCPU*LVL_N-1:0]  mask_vec,
    input logic [NCPU-1:0]        swi_vec,
    input logic [NCPU-1:0]        tick_vec
);
    assert_rst_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RESET_ALL_ADDR) |=> cpu_reset_all);
    assert_rst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == RESET_ALL_ADDR) |=> !cpu_reset_all);

    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] SWI_A = ADDR_W'(c * 16 + 4);
        localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(c * 16 + 8);

        assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] == (cpu_level[c*CODE_W +: CODE_W] != '0));
        assert_mask_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_vec[c*LVL_N +: LVL_N] == '0) |=> (cpu_level[c*CODE_W +: CODE_W] == '0));
        assert_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_level[c*CODE_W +: CODE_W] <= CODE_W'(LVL_N));
        assert_swi_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == SWI_A && (&bus_wdata)) |=> swi_vec[c]);
        assert_tick_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
            timer_tick[c] |=> tick_vec[c]);
        assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ACK_A && (&bus_wdata) && !timer_tick[c]) |=> !tick_vec[c]);
    end
endmodule

bind percpu_irq_ctrl irqc_sva #(
    .NCPU(NCPU), .ADDR_W(ADDR_W), .RESET_ALL_ADDR(RESET_ALL_ADDR)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .timer_tick    (timer_tick),
    .cpu_level     (cpu_level),
    .cpu_irq       (cpu_irq),
    .cpu_reset_all (cpu_reset_all),
    .mask_vec      (mask_vec),
    .swi_vec       (swi_vec),
    .tick_vec      (tick_vec)
);

// File: tb/tb_percpu_irq_ctrl.sv
module tb_percpu_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  ext_irq = '0;
    logic [3:0]  timer_tick = '0;
    logic [11:0] cpu_level;
    logic [3:0]  cpu_irq;
    logic        cpu_reset_all;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    percpu_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_irq(ext_irq), .timer_tick(timer_tick), .cpu_level(cpu_level),
        .cpu_irq(cpu_irq), .cpu_reset_all(cpu_reset_all)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_tick(input int c);
        @(negedge clk);
        timer_tick[c] = 1'b1;
        @(negedge clk);
        timer_tick[c] = 1'b0;
    endtask

    function automatic logic [2:0] exp_level(input logic [5:0] p, input logic [5:0] m);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 1; i <= 6; i++) if (p[i-1] && m[i-1]) r = 3'(i);
        return r;
    endfunction

    function automatic logic [2:0] lvl_of(input int c);
        return cpu_level[c*3 +: 3];
    endfunction

    // clear software and timer pending state of cpu c
    task automatic clear_cpu(input int c);
        logic [31:0] d;
        bus_read(8'(c*16 + 4), d);
        bus_write(8'(c*16 + 8), 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cpu_level == '0, "R1 levels", 32'(cpu_level), 0);
        chk(cpu_irq == '0, "R1 irq", 32'(cpu_irq), 0);
        chk(cpu_reset_all == 1'b0, "R1 reset_all", 32'(cpu_reset_all), 0);
        for (int c = 0; c < NCPU; c++) begin
            bus_read(8'(c*16), d);
            chk(d == 32'h0, "R1 status readback", d, 0);
        end

        // R2 R3 R4 R5: exhaustive sweep of pending pattern x mask on each cpu
        for (int c = 0; c < NCPU; c++) begin
            for (int p = 0; p < 64; p++) begin
                logic [5:0] pv;
                pv = 6'(p);
                @(negedge clk);
                ext_irq = {pv[5], pv[3], pv[2], pv[1]};
                clear_cpu(c);
                if (pv[0]) bus_write(8'(c*16 + 4), 32'hFFFF_FFFF);
                if (pv[4]) pulse_tick(c);
                for (int m = 0; m < 64; m++) begin
                    logic [5:0]  mv;
                    logic [2:0]  el;
                    logic [31:0] er;
                    mv = 6'(m);
                    el = exp_level(pv, mv);
                    er = {el, 5'b0, mv, 18'b0};
                    bus_write(8'(c*16), {mv, 26'h155_5555});
                    bus_read(8'(c*16), d);
                    chk(d == er, "R2 R3 status readback", d, er);
                    chk(lvl_of(c) == el, "R4 level", 32'(lvl_of(c)), 32'(el));
                    chk(cpu_irq[c] == (el != 0), "R5 irq", 32'(cpu_irq[c]), 32'(el != 0));
                end
            end
        end
        ext_irq = '0;

        // all masks on, everything clear
        for (int c = 0; c < NCPU; c++) begin
            bus_write(8'(c*16), 32'hFC00_0000);
            clear_cpu(c);
        end
        @(negedge clk);
        chk(cpu_level == '0, "R10 all clear", 32'(cpu_level), 0);

        // R5: external request timing, one edge
        @(negedge clk);
        ext_irq = 4'b0001;
        #1 chk(lvl_of(0) == 3'd0, "R5 before edge", 32'(lvl_of(0)), 0);
        @(negedge clk);
        chk(lvl_of(0) == 3'd2, "R5 after one edge", 32'(lvl_of(0)), 2);
        ext_irq = 4'b1000;
        @(negedge clk);
        chk(lvl_of(3) == 3'd6, "R4 ext3 is level 6", 32'(lvl_of(3)), 6);
        ext_irq = 4'b0000;
        @(negedge clk);

        // R6: non-all-ones swi write ignored
        bus_write(8'h24, 32'hFFFF_FFFE);
        @(negedge clk);
        chk(lvl_of(2) == 3'd0, "R6 partial write ignored", 32'(lvl_of(2)), 0);
        // R6 R10: post swi to cpu2 only
        bus_write(8'h24, 32'hFFFF_FFFF);
        @(negedge clk);
        chk(lvl_of(2) == 3'd1, "R6 swi posted", 32'(lvl_of(2)), 1);
        chk(lvl_of(0) == 0 && lvl_of(1) == 0 && lvl_of(3) == 0, "R10 swi isolation",
            32'(cpu_level), 32'h040);
        // R7: read clears, data zero
        bus_read(8'h24, d);
        chk(d == 32'h0, "R7 swi read data", d, 0);
        @(negedge clk);
        chk(lvl_of(2) == 3'd0, "R7 swi cleared", 32'(lvl_of(2)), 0);

        // R8 R10: tick to cpu1
        pulse_tick(1);
        @(negedge clk);
        chk(lvl_of(1) == 3'd5, "R8 tick pending", 32'(lvl_of(1)), 5);
        chk(lvl_of(0) == 0 && lvl_of(2) == 0 && lvl_of(3) == 0, "R10 tick isolation",
            32'(cpu_level), 32'h028);
        bus_write(8'h18, 32'h0000_FFFF);
        @(negedge clk);
        chk(lvl_of(1) == 3'd5, "R8 partial ack ignored", 32'(lvl_of(1)), 5);
        bus_write(8'h08, 32'hFFFF_FFFF);
        @(negedge clk);
        chk(lvl_of(1) == 3'd5, "R10 ack on other cpu", 32'(lvl_of(1)), 5);
        bus_write(8'h18, 32'hFFFF_FFFF);
        @(negedge clk);
        chk(lvl_of(1) == 3'd0, "R8 ack clears", 32'(lvl_of(1)), 0);

        // R9: coincident tick and ack
        @(negedge clk);
        bus_addr = 8'h18; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; timer_tick[1] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; timer_tick[1] = 1'b0;
        @(negedge clk);
        chk(lvl_of(1) == 3'd5, "R9 tick beats ack", 32'(lvl_of(1)), 5);
        // R9: coincident swi post and clearing read
        @(negedge clk);
        bus_addr = 8'h34; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
        chk(lvl_of(3) == 3'd1, "R9 post beats read", 32'(lvl_of(3)), 1);

        // R11: reset-all pulse
        bus_write(8'h00, 32'hFC00_0000);
        chk(cpu_reset_all == 1'b0, "R11 no pulse on other write", 32'(cpu_reset_all), 0);
        @(negedge clk);
        bus_addr = 8'h40; bus_wdata = 32'h0000_0000; bus_wr = 1'b1;
        #1 chk(cpu_reset_all == 1'b0, "R11 low before edge", 32'(cpu_reset_all), 0);
        @(negedge clk);
        bus_wr = 1'b0;
        chk(cpu_reset_all == 1'b1, "R11 pulse high", 32'(cpu_reset_all), 1);
        @(negedge clk);
        chk(cpu_reset_all == 1'b0, "R11 pulse one cycle", 32'(cpu_reset_all), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule